// File: doc/BRIEF.md
# Two-Way Hold-or-Pass Bus Transceiver

This block joins two 18-bit shared buses, A and B, through two independent and symmetric lanes. One lane carries A toward B and the other carries B toward A. Each lane holds one storage word. A pass input makes that word follow its source bus on every clock. When pass is low, the word keeps its value, and it loads a fresh copy of the source bus only when the lane's strobe input goes from high to low. Each lane also has an output enable that decides whether it drives its destination bus or leaves it floating. Data is never inverted.

All pins are sampled by one system clock. The storage word updates on the rising system-clock edge that sees the controls. A strobe fall counts when the strobe is high at one sampling edge and low at the next. The output enables act combinationally on the bus drivers, so a bus is taken or released without waiting for a clock. The A-to-B enable is active high and the B-to-A enable is active low. The block does not resolve the case where both lanes drive at once, and the surrounding logic must avoid it.

Top module: `duplex_hold_xcvr`

## Requirements
- R1: Every bit of the lane word reaches the destination bus unchanged: bit i of B equals bit i of A for all 18 bits, with no inversion and no reordering.
- R2: If `ab_open` is 1 at a rising clk edge, the A-to-B word takes the value on A at that edge, and B shows it from that edge on.
- R3: If `ab_open` is 0 and `ab_strobe` is at the same level at two consecutive edges, the A-to-B word keeps its value whatever A does.
- R4: If `ab_open` is 0, `ab_strobe` is 1 at one edge and 0 at the next, the word loads the value on A at that second edge.
- R5: A rise of `ab_strobe` (0 at one edge, 1 at the next) while `ab_open` is 0 leaves the word unchanged.
- R6: When `ab_open` goes from 1 to 0 without a strobe fall, the word keeps the A value sampled at the last edge where `ab_open` was 1.
- R7: `ab_drive` is active high and acts without a clock. At 1, B carries the A-to-B word. At 0, B is released, so a value placed on B by another driver reads back intact.
- R8: The B-to-A lane obeys R2 to R6 with `ba_open`, `ba_strobe` and B as its source.
- R9: `ba_drive_n` is active low and acts without a clock. At 0, A carries the B-to-A word. At 1, A is released.
- R10: While `rst_n` is 0, both words are all zeros and both recorded strobe levels are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low clear of both words |
| a_io | inout | 18 | Bus A: source of A-to-B, destination of B-to-A |
| b_io | inout | 18 | Bus B: source of B-to-A, destination of A-to-B |
| ab_open | input | 1 | A-to-B pass (word follows A when 1) |
| ab_strobe | input | 1 | A-to-B load strobe, acts on its falling transition |
| ab_drive | input | 1 | A-to-B output enable, active high |
| ba_open | input | 1 | B-to-A pass (word follows B when 1) |
| ba_strobe | input | 1 | B-to-A load strobe, acts on its falling transition |
| ba_drive_n | input | 1 | B-to-A output enable, active low |

## Verification
A word that loads on the wrong strobe transition, or misses a pass cycle, shows up on the enabled destination bus one clock after the edge in question. The bench therefore sweeps every pair of consecutive pass and strobe levels and reads the bus at the next falling clock. A wrong enable polarity or a driver that fails to release shows up at once as a corrupted readback of a value the bench places on the bus. A swapped or inverted bit shows up in a walking-one pass through the transparent lane.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    CAP_HOLD   = 2'd0,
    CAP_FOLLOW = 2'd1,
    CAP_EDGE   = 2'd2
  } cap_mode_e;

  function automatic logic strobe_fell(input logic prev_lvl, input logic now_lvl);
    return prev_lvl & ~now_lvl;
  endfunction

  function automatic logic strobe_rose(input logic prev_lvl, input logic now_lvl);
    return ~prev_lvl & now_lvl;
  endfunction

  // pass has priority over the strobe; otherwise only a fall loads
  function automatic cap_mode_e pick_mode(input logic open_lvl, input logic fell);
    if (open_lvl) return CAP_FOLLOW;
    if (fell)     return CAP_EDGE;
    return CAP_HOLD;
  endfunction

  function automatic logic enable_on(input logic pin, input bit active_high);
    return active_high ? pin : ~pin;
  endfunction

endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fell,
  output logic rose
);
  import xcvr_pkg::*;

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe;
  end

  assign fell = strobe_fell(prev_q, strobe);
  assign rose = strobe_rose(prev_q, strobe);
endmodule

// File: rtl/xcvr_hold_stage.sv
module xcvr_hold_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_lvl,
  input  logic         fell,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  import xcvr_pkg::*;

  cap_mode_e mode;
  logic [W-1:0] q_next;

  assign mode = pick_mode(open_lvl, fell);

  always_comb begin
    case (mode)
      CAP_FOLLOW: q_next = din;
      CAP_EDGE:   q_next = din;
      default:    q_next = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W              = 18,
  parameter bit OE_ACTIVE_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         open_lvl,
  input  logic         strobe,
  input  logic         oe_pin,
  output logic [W-1:0] q,
  output logic         drive_on,
  output logic         fell,
  output logic         rose
);
  import xcvr_pkg::*;

  xcvr_strobe_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .fell   (fell),
    .rose   (rose)
  );

  xcvr_hold_stage #(.W(W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_lvl (open_lvl),
    .fell     (fell),
    .din      (din),
    .q        (q)
  );

  generate
    if (OE_ACTIVE_HIGH) begin : g_oe_high
      assign drive_on = enable_on(oe_pin, 1'b1);
    end else begin : g_oe_low
      assign drive_on = enable_on(oe_pin, 1'b0);
    end
  endgenerate
endmodule

// File: rtl/duplex_hold_xcvr.sv
module duplex_hold_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io,
  input  logic         ab_open,
  input  logic         ab_strobe,
  input  logic         ab_drive,
  input  logic         ba_open,
  input  logic         ba_strobe,
  input  logic         ba_drive_n
);
  localparam int NDIR  = 2;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;

  logic [W-1:0]    lane_din [NDIR];
  logic [W-1:0]    lane_q   [NDIR];
  logic [NDIR-1:0] lane_open, lane_strobe, lane_oe, lane_on, lane_fell, lane_rose;

  assign lane_din[DIR_AB] = a_io;
  assign lane_din[DIR_BA] = b_io;
  assign lane_open   = {ba_open,    ab_open};
  assign lane_strobe = {ba_strobe,  ab_strobe};
  assign lane_oe     = {ba_drive_n, ab_drive};

  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_lane
      xcvr_lane #(.W(W), .OE_ACTIVE_HIGH(d == DIR_AB)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (lane_din[d]),
        .open_lvl (lane_open[d]),
        .strobe   (lane_strobe[d]),
        .oe_pin   (lane_oe[d]),
        .q        (lane_q[d]),
        .drive_on (lane_on[d]),
        .fell     (lane_fell[d]),
        .rose     (lane_rose[d])
      );
    end
  endgenerate

  // named internal events for the bound checker
  logic [W-1:0] ab_store, ba_store;
  logic         ab_on, ba_on, ab_fell, ba_fell, ab_rose, ba_rose;

  assign ab_store = lane_q[DIR_AB];
  assign ba_store = lane_q[DIR_BA];
  assign ab_on    = lane_on[DIR_AB];
  assign ba_on    = lane_on[DIR_BA];
  assign ab_fell  = lane_fell[DIR_AB];
  assign ba_fell  = lane_fell[DIR_BA];
  assign ab_rose  = lane_rose[DIR_AB];
  assign ba_rose  = lane_rose[DIR_BA];

  assign b_io = ab_on ? ab_store : {W{1'bz}};
  assign a_io = ba_on ? ba_store : {W{1'bz}};
endmodule

// File: rtl/duplex_hold_xcvr_chk.sv
module duplex_hold_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_io,
  input logic [W-1:0] b_io,
  input logic         ab_open,
  input logic         ba_open,
  input logic         ab_drive,
  input logic         ba_drive_n,
  input logic [W-1:0] ab_store,
  input logic [W-1:0] ba_store,
  input logic         ab_fell,
  input logic         ba_fell,
  input logic         ab_rose,
  input logic         ba_rose
);
  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ab_open |=> ab_store == $past(a_io));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_open && !ab_fell && !ab_rose) |=> $stable(ab_store));

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_open && ab_fell) |=> ab_store == $past(a_io));

  p_rise_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_open && ab_rose) |=> $stable(ab_store));

  p_drive_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ab_drive |-> b_io == ab_store);

  p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ba_open |=> ba_store == $past(b_io));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_open && ba_fell) |=> ba_store == $past(b_io));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_open && !ba_fell) |=> $stable(ba_store));

  p_rise_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_open && ba_rose) |=> $stable(ba_store));

  p_drive_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ba_drive_n |-> a_io == ba_store);
endmodule

bind duplex_hold_xcvr duplex_hold_xcvr_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .a_io       (a_io),
  .b_io       (b_io),
  .ab_open    (ab_open),
  .ba_open    (ba_open),
  .ab_drive   (ab_drive),
  .ba_drive_n (ba_drive_n),
  .ab_store   (ab_store),
  .ba_store   (ba_store),
  .ab_fell    (ab_fell),
  .ba_fell    (ba_fell),
  .ab_rose    (ab_rose),
  .ba_rose    (ba_rose)
);

// File: tb/duplex_hold_xcvr_bench.sv
module duplex_hold_xcvr_bench;
  localparam int W = 18;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  wire  [W-1:0] a_io, b_io;
  logic [W-1:0] a_drv = '0, b_drv = '0;
  logic         a_en = 1'b0, b_en = 1'b0;
  logic ab_open = 0, ab_strobe = 0, ab_drive = 0;
  logic ba_open = 0, ba_strobe = 0, ba_drive_n = 1;

  assign a_io = a_en ? a_drv : {W{1'bz}};
  assign b_io = b_en ? b_drv : {W{1'bz}};

  duplex_hold_xcvr #(.W(W)) u_duplex_hold_xcvr (
    .clk(clk), .rst_n(rst_n), .a_io(a_io), .b_io(b_io),
    .ab_open(ab_open), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
    .ba_open(ba_open), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // requirement model of the two words and recorded strobe levels
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic prev_ab = 0, prev_ba = 0;

  function automatic logic [W-1:0] pat(input int k);
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = ((i * 3 + k * 5) % 7) < 3;
    return v;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // inputs are already set at the falling edge; advance one rising edge
  task automatic tick();
    if (ab_open || (prev_ab && !ab_strobe)) m_ab = a_drv;
    if (ba_open || (prev_ba && !ba_strobe)) m_ba = b_drv;
    prev_ab = ab_strobe;
    prev_ba = ba_strobe;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic o0, input logic s0, input logic o1, input logic s1);
    if (o1)             return "R2 pass";
    if (s0 && !s1)      return "R4 fall load";
    if (!s0 && s1)      return "R5 rise ignored";
    if (o0)             return "R6 close keeps";
    return "R3 hold";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    @(negedge clk);
    // R10: reset state, A-to-B word seen on B
    a_en = 1; a_drv = pat(1); ab_drive = 1; ba_drive_n = 1;
    ab_open = 1;
    repeat (2) @(negedge clk);
    #1 check("R10 reset A-to-B word", b_io, '0);
    ab_open = 0; ab_drive = 0; a_en = 0;
    b_en = 1; b_drv = pat(2); ba_open = 1; ba_drive_n = 0;
    #1 check("R10 reset B-to-A word", a_io, '0);
    ba_open = 0; ba_drive_n = 1;
    @(negedge clk);
    rst_n = 1'b1;

    // A-to-B configuration
    b_en = 0; a_en = 1; ab_drive = 1;
    // R1: walking one through the pass lane
    ab_open = 1;
    for (int i = 0; i < W; i++) begin
      a_drv = '0; a_drv[i] = 1'b1;
      tick();
      check($sformatf("R1 bit %0d", i), b_io, a_drv);
    end

    // near-exhaustive sweep of consecutive control pairs, A to B
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 4; n++)
        for (int k = 0; k < 4; k++) begin
          ab_open = p[1]; ab_strobe = p[0]; a_drv = pat(k * 2 + p);
          tick();
          ab_open = n[1]; ab_strobe = n[0]; a_drv = pat(k * 2 + n + 9);
          tick();
          check(tag_of(p[1], p[0], n[1], n[0]), b_io, m_ab);
        end

    ab_open = 0;
    tick();
    check("R3 hold after sweep", b_io, m_ab);

    // B-to-A configuration; A-to-B strobe left untouched
    ab_drive = 0; b_en = 1; b_drv = pat(3);
    a_en = 0; ba_drive_n = 0;
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 4; n++)
        for (int k = 0; k < 4; k++) begin
          ba_open = p[1]; ba_strobe = p[0]; b_drv = pat(k * 3 + p + 4);
          tick();
          ba_open = n[1]; ba_strobe = n[0]; b_drv = pat(k * 3 + n + 17);
          tick();
          check({"R8 ", tag_of(p[1], p[0], n[1], n[0])}, a_io, m_ba);
        end
    ba_open = 0;
    tick();

    // R7: release and drive of B without a clock
    b_en = 1; b_drv = ~m_ab; ab_drive = 0;
    #1 check("R7 B released", b_io, ~m_ab);
    b_en = 0; ab_drive = 1;
    #1 check("R7 B driven", b_io, m_ab);

    // R9: release and drive of A without a clock
    ba_drive_n = 1; a_en = 1; a_drv = ~m_ba;
    #1 check("R9 A released", a_io, ~m_ba);
    a_en = 0; ba_drive_n = 0;
    #1 check("R9 A driven", a_io, m_ba);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule